// File: doc/BRIEF.md
# Supply and Fault Supervisor for a Flyback PWM Controller

This block decides when the PWM logic may switch. It runs from five comparator flags and one extra supply flag. Two of the supply flags form the under-voltage window: switching may begin once the supply passes the start level, and it stops when the supply falls below the stop level. A separate flag marks a supply too low to hold a latched fault.

Three fault inputs are filtered by consecutive-cycle debouncers: supply over-voltage, thermistor pin below its trip level, and feedback held at its open-loop level. The two thermal and over-voltage faults lock the output off. Only a collapse of the supply below the holding level releases that lock. An open-loop fault instead forces a shutdown and then waits for the supply to fall through the stop level. The block then recharges to the start level and tries again, which gives a hiccup retry for as long as the overload lasts.

All delays are counts of clock cycles set by parameters, so a bench can use short values. The state is visible as a two-bit code, together with the fault cause bits and an open-loop indicator.

Top module: `prot_supervisor`

## Requirements
- R1: After synchronous reset the state code is 0 (off), `run_en` is 0, and `latch_ovp`, `latch_otp` and `olp_off` are 0.
- R2: From the off state (code 0), the block moves to run (code 1) on the first clock edge at which `vdd_start_ok` is 1, and it stays off otherwise. `run_en` is 1 exactly while the state code is 1.
- R3: In run, `vdd_stop_low` at a clock edge returns the block to off (code 0), unless a latching fault trips at that same edge.
- R4: In run, `vdd_over` held high for OVP_DLY consecutive edges moves the block at the last of those edges to the latched state (code 3), with `latch_ovp` set to 1.
- R5: In run, `therm_low` held high for OTP_DLY consecutive edges moves the block at the last of those edges to the latched state (code 3), with `latch_otp` set to 1.
- R6: Each debouncer restarts its count from zero whenever its fault flag is sampled low. A run of highs shorter than the delay therefore never trips it, however many such runs occur.
- R7: In run, `fb_open` held high for OLP_DLY consecutive edges moves the block to the open-loop wait state (code 2). `olp_off` is then 1 and `run_en` is 0.
- R8: In open-loop wait, `vdd_start_ok` has no effect. Only `vdd_stop_low` leaves the state, and it goes to off, from which a later `vdd_start_ok` restarts switching.
- R9: In the latched state, `vdd_stop_low` and `vdd_start_ok` have no effect. `vdd_hold_low` moves the block to off and clears both cause bits.
- R10: When a latching fault trips in run at the same edge as `vdd_stop_low` or an open-loop trip, the latched state wins.
- R11: Fault flags have no effect outside run. Debounce counts begin only when the block is in run, so a fault present before entry needs its full delay after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vdd_start_ok | input | 1 | Supply above start threshold |
| vdd_stop_low | input | 1 | Supply below stop threshold |
| vdd_hold_low | input | 1 | Supply below latch-holding level |
| vdd_over | input | 1 | Supply over-voltage comparator |
| therm_low | input | 1 | Thermistor pin below trip level |
| fb_open | input | 1 | Feedback above open-loop level |
| run_en | output | 1 | Switching permitted |
| state_o | output | 2 | State code: 0 off, 1 run, 2 open-loop wait, 3 latched |
| latch_ovp | output | 1 | Latched cause: over-voltage |
| latch_otp | output | 1 | Latched cause: over-temperature |
| olp_off | output | 1 | Open-loop shutdown in progress |

## Verification
The assertions check, on every cycle, the rules that hold from one state to the next. These are: a latched state that persists without the holding flag, an open-loop wait that persists without the stop flag, latching priority over other exits from run, cause bits that appear only while latched, and debounce counts that stay in range. The exact edge at which a debounced fault trips can only be shown by the bench scenarios. The same holds for the restart of a count after a short glitch, the full-delay requirement for a fault already present on entry to run, and the complete hiccup sequence of off, run, wait, off and run. The bench checks these against a cycle model and a long random run with slowly toggling fault flags.

// File: rtl/sup_pkg.sv
package sup_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_OLPW  = 2'd2,
        ST_LATCH = 2'd3
    } sup_state_e;

    // Debounced fault trips, one bit per fault source
    typedef struct packed {
        logic olp;
        logic otp;
        logic ovp;
    } trip_s;

    localparam int NUM_FAULTS = 3;

    function automatic int cnt_width(input int dly);
        return (dly < 2) ? 1 : $clog2(dly);
    endfunction

endpackage

// File: rtl/sup_debounce.sv
module sup_debounce #(
    parameter int DLY = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic flag,
    output logic trip
);
    import sup_pkg::*;

    localparam int W = cnt_width(DLY);
    localparam logic [W-1:0] LAST = W'(DLY - 1);

    logic [W-1:0] cnt;
    logic         active;

    assign active = en && flag;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // Trips on the DLY-th consecutive qualified sample
    assign trip = active && (cnt == LAST);

    // R6: count never passes the trip point
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R6: a low sample restarts the count
    p_restart_r6: assert property (@(posedge clk) disable iff (rst)
        !active |=> (cnt == '0));

endmodule

// File: rtl/sup_fsm.sv
module sup_fsm (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_ok,
    input  logic               stop_low,
    input  logic               hold_low,
    input  sup_pkg::trip_s     trips,
    output sup_pkg::sup_state_e state,
    output logic               cause_ovp,
    output logic               cause_otp
);
    import sup_pkg::*;

    sup_state_e nxt;
    logic       latch_trip;

    assign latch_trip = trips.ovp || trips.otp;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:   if (start_ok) nxt = ST_RUN;
            ST_RUN: begin
                if (latch_trip)     nxt = ST_LATCH;
                else if (stop_low)  nxt = ST_OFF;
                else if (trips.olp) nxt = ST_OLPW;
            end
            ST_OLPW:  if (stop_low) nxt = ST_OFF;
            ST_LATCH: if (hold_low) nxt = ST_OFF;
            default:  nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OFF;
            cause_ovp <= 1'b0;
            cause_otp <= 1'b0;
        end else begin
            state <= nxt;
            if (nxt != ST_LATCH) begin
                cause_ovp <= 1'b0;
                cause_otp <= 1'b0;
            end else if (state == ST_RUN) begin
                cause_ovp <= trips.ovp;
                cause_otp <= trips.otp;
            end
        end
    end

    // R2: off is left only through the start flag
    p_off_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OFF) && !start_ok |=> (state == ST_OFF));

    // R3: stop flag without a latching trip ends run
    p_stop_exit_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) && stop_low && !latch_trip |=> (state == ST_OFF));

    // R4, R5: cause bits only while latched
    p_cause_latched_r4: assert property (@(posedge clk) disable iff (rst)
        (cause_ovp || cause_otp) |-> (state == ST_LATCH));

    // R8: open-loop wait persists until stop flag
    p_olpw_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OLPW) && !stop_low |=> (state == ST_OLPW));

    // R9: latch persists until supply collapses
    p_latch_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LATCH) && !hold_low |=> (state == ST_LATCH));

    // R10: latching trip wins over every other exit from run
    p_latch_prio_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN) && latch_trip |=> (state == ST_LATCH) && (cause_ovp || cause_otp));

endmodule

// File: rtl/prot_supervisor.sv
module prot_supervisor #(
    parameter int OVP_DLY = 100,
    parameter int OTP_DLY = 100,
    parameter int OLP_DLY = 56000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       vdd_start_ok,
    input  logic       vdd_stop_low,
    input  logic       vdd_hold_low,
    input  logic       vdd_over,
    input  logic       therm_low,
    input  logic       fb_open,
    output logic       run_en,
    output logic [1:0] state_o,
    output logic       latch_ovp,
    output logic       latch_otp,
    output logic       olp_off
);
    import sup_pkg::*;

    sup_state_e            state;
    logic [NUM_FAULTS-1:0] flags;
    logic [NUM_FAULTS-1:0] trip_v;
    trip_s                 trips;
    logic                  in_run;

    assign flags  = {fb_open, therm_low, vdd_over};
    assign in_run = (state == ST_RUN);

    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_deb
        localparam int D = (i == 0) ? OVP_DLY : (i == 1) ? OTP_DLY : OLP_DLY;
        sup_debounce #(.DLY(D)) u_deb (
            .clk  (clk),
            .rst  (rst),
            .en   (in_run),
            .flag (flags[i]),
            .trip (trip_v[i])
        );
    end

    assign trips = trip_s'(trip_v);

    sup_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start_ok  (vdd_start_ok),
        .stop_low  (vdd_stop_low),
        .hold_low  (vdd_hold_low),
        .trips     (trips),
        .state     (state),
        .cause_ovp (latch_ovp),
        .cause_otp (latch_otp)
    );

    assign run_en  = in_run;
    assign state_o = state;
    assign olp_off = (state == ST_OLPW);

    // R2: switching begins only after the start flag was seen
    p_run_entry_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(run_en) |-> $past(vdd_start_ok));

    // R11: no fault trip can occur outside run
    p_trip_in_run_r11: assert property (@(posedge clk) disable iff (rst)
        (trip_v != '0) |-> in_run);

endmodule

// File: tb/prot_supervisor_test.sv
module prot_supervisor_test;

    localparam int OVP_N = 6;
    localparam int OTP_N = 9;
    localparam int OLP_N = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_ok = 0, stop_low = 0, hold_low = 0, over = 0, therm = 0, fb = 0;
    logic       run_en, latch_ovp, latch_otp, olp_off;
    logic [1:0] state_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state
    int ms = 0;
    int c_ov = 0, c_ot = 0, c_ol = 0;
    bit m_cov = 0, m_cot = 0;

    always #2 clk = ~clk;

    prot_supervisor #(.OVP_DLY(OVP_N), .OTP_DLY(OTP_N), .OLP_DLY(OLP_N)) uut (
        .clk(clk), .rst(rst),
        .vdd_start_ok(start_ok), .vdd_stop_low(stop_low), .vdd_hold_low(hold_low),
        .vdd_over(over), .therm_low(therm), .fb_open(fb),
        .run_en(run_en), .state_o(state_o),
        .latch_ovp(latch_ovp), .latch_otp(latch_otp), .olp_off(olp_off)
    );

    task automatic chk(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Next model state from current model and inputs (requirements R2-R11)
    task automatic m_step();
        bit in_run = (ms == 1);
        int nov = (in_run && over)  ? c_ov + 1 : 0;
        int not_ = (in_run && therm) ? c_ot + 1 : 0;
        int nol = (in_run && fb)    ? c_ol + 1 : 0;
        bit tov = nov >= OVP_N, tot = not_ >= OTP_N, tol = nol >= OLP_N;
        int nxt = ms;
        case (ms)
            0: if (start_ok) nxt = 1;
            1: if (tov || tot) nxt = 3; else if (stop_low) nxt = 0; else if (tol) nxt = 2;
            2: if (stop_low) nxt = 0;
            default: if (hold_low) nxt = 0;
        endcase
        if (nxt != 3) begin m_cov = 0; m_cot = 0; end
        else if (ms == 1) begin m_cov = tov; m_cot = tot; end
        ms = nxt; c_ov = nov; c_ot = not_; c_ol = nol;
    endtask

    task automatic cmp(input string tag);
        chk(tag, state_o, ms, "state");
        chk(tag, run_en, (ms == 1), "run_en");
        chk(tag, latch_ovp, m_cov, "latch_ovp");
        chk(tag, latch_otp, m_cot, "latch_otp");
        chk(tag, olp_off, (ms == 2), "olp_off");
    endtask

    task automatic cyc(input string tag);
        m_step();
        @(posedge clk);
        #1;
        cmp(tag);
    endtask

    task automatic clr();
        start_ok = 0; stop_low = 0; hold_low = 0; over = 0; therm = 0; fb = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5842));
        repeat (3) @(posedge clk);
        #1 rst = 0;
        // R1: reset state
        chk("R1", state_o, 0, "state");
        chk("R1", run_en, 0, "run_en");
        chk("R1", latch_ovp + latch_otp + olp_off, 0, "status");

        // R2: stays off without start flag, then enters run
        repeat (4) cyc("R2");
        chk("R2", run_en, 0, "run_en idle");
        start_ok = 1; cyc("R2");
        chk("R2", run_en, 1, "run_en after start");
        start_ok = 0;

        // R3: stop flag ends run
        stop_low = 1; cyc("R3");
        chk("R3", state_o, 0, "state after stop");
        clr(); start_ok = 1; cyc("R3"); start_ok = 0;

        // R4: over-voltage trips on the OVP_N-th edge
        over = 1;
        repeat (OVP_N - 1) cyc("R4");
        chk("R4", run_en, 1, "run_en before trip");
        cyc("R4");
        chk("R4", state_o, 3, "state latched");
        chk("R4", latch_ovp, 1, "latch_ovp");
        over = 0;

        // R9: latched ignores stop and start; hold_low releases
        stop_low = 1; start_ok = 1; repeat (5) cyc("R9");
        chk("R9", state_o, 3, "still latched");
        clr(); hold_low = 1; cyc("R9");
        chk("R9", state_o, 0, "released");
        chk("R9", latch_ovp, 0, "cause cleared");
        clr(); start_ok = 1; cyc("R9"); start_ok = 0;

        // R6: short therm glitch restarts count; R5: full delay latches
        therm = 1; repeat (OTP_N - 1) cyc("R6");
        therm = 0; cyc("R6");
        therm = 1; repeat (OTP_N - 1) cyc("R6");
        chk("R6", run_en, 1, "no trip after restart");
        cyc("R5");
        chk("R5", latch_otp, 1, "latch_otp");
        chk("R5", latch_ovp, 0, "latch_ovp");
        clr(); hold_low = 1; cyc("R5"); clr(); start_ok = 1; cyc("R5"); start_ok = 0;

        // R7, R8: open-loop hiccup
        fb = 1; repeat (OLP_N) cyc("R7");
        chk("R7", olp_off, 1, "olp_off");
        chk("R7", run_en, 0, "run_en");
        start_ok = 1; repeat (3) cyc("R8");
        chk("R8", state_o, 2, "start ignored in wait");
        start_ok = 0; stop_low = 1; cyc("R8");
        chk("R8", state_o, 0, "off after stop");
        stop_low = 0; start_ok = 1; cyc("R8");
        chk("R8", run_en, 1, "restart");
        clr();

        // R10: latching trip beats stop and open-loop at same edge
        over = 1; repeat (OVP_N - 1) cyc("R10");
        stop_low = 1; cyc("R10");
        chk("R10", state_o, 3, "latch wins");
        clr(); hold_low = 1; cyc("R10"); clr();

        // R11: fault before entry needs full delay after entry
        therm = 1; repeat (15) cyc("R11");
        chk("R11", state_o, 0, "off ignores fault");
        start_ok = 1; cyc("R11"); start_ok = 0;
        repeat (OTP_N - 1) cyc("R11");
        chk("R11", run_en, 1, "count started at entry");
        cyc("R11");
        chk("R11", latch_otp, 1, "trip after full delay");
        clr(); hold_low = 1; cyc("R11"); clr();

        // Random phase: slowly toggling faults against the model
        for (int i = 0; i < 6000; i++) begin
            start_ok = ($urandom_range(0, 3) == 0);
            stop_low = ($urandom_range(0, 15) == 0);
            hold_low = ($urandom_range(0, 31) == 0);
            if ($urandom_range(0, 19) == 0) over  = ~over;
            if ($urandom_range(0, 19) == 0) therm = ~therm;
            if ($urandom_range(0, 39) == 0) fb    = ~fb;
            cyc("R2-model");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule